// File: doc/BRIEF.md
# UART interrupt identification unit

This block merges the interrupt sources of a UART into one active-high interrupt line. It also produces an 8-bit identification value that software reads to learn which source to service. There are four source groups: receive-line errors, receive data availability (with the FIFO character timeout as a sibling), transmit-holding-buffer empty, and modem handshake changes. Each group is gated by one bit of an interrupt enable register. The highest-priority enabled pending source is reported as a 4-bit code.

Error and handshake-change indications arrive as one-cycle event pulses. The unit holds each one in a pending flag until the register access that acknowledges it, which it sees as a strobe. Receive data availability arrives as a level from the FIFO logic and is used as it stands. Transmit-empty is raised when the buffer becomes empty, or when its enable is switched on while the buffer is already empty. It is dropped by a write to the transmit buffer, or by a read of the identification register while it is the reported source.

A registered selector walks six named states every clock: `ST_IDLE` (nothing pending), `ST_LINE`, `ST_RXDATA`, `ST_TMO`, `ST_THRE` and `ST_MODEM`. From any state it moves in one transition to the state of the highest-priority source that is both enabled and pending in the next cycle. It moves to `ST_IDLE` when none is. The interrupt output is registered in the same edge, so the line and the reported code always agree.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register keeps bits 3..0 on a write (bit 0 receive data and timeout, bit 1 transmit empty, bit 2 line status, bit 3 handshake). Bits 7..4 always read back as zero.
- R2: With enable bits 3..0 all zero, `irq` stays low whatever sources are pending. Sources latched meanwhile still report once they are enabled.
- R3: `isr_rdata[3:0]` reads 0001 and `irq` is low when no enabled source is pending. `irq` is high exactly when that code differs from 0001.
- R4: Any bit of `line_err` raises the line source, code 0110, which has the highest priority. `lsr_rd` clears it.
- R5: `rx_ready` high reports code 0100 below the line source. When both are pending it takes precedence over the timeout code, and it drops when `rx_ready` falls.
- R6: A `rx_timeout` pulse with `fifo_en` high reports code 1100 and `rbr_rd` clears it. With `fifo_en` low the timeout source is discarded and never reported.
- R7: A rising edge of `tx_empty` reports code 0010. It is cleared by `thr_wr`, or by `isr_rd` in a cycle where 0010 is the reported code.
- R8: An `isr_rd` while a higher-priority code is reported leaves a pending transmit-empty source intact.
- R9: Setting enable bit 1 while `tx_empty` is already high raises the transmit-empty source.
- R10: Any bit of `hs_delta` raises the handshake source, code 0000 with `irq` high and the lowest priority. `hsr_rd` clears it.
- R11: `isr_rdata[7:4]` reads 1100 when `fifo_en` was high at the previous edge, and 0000 otherwise.
- R12: `irq` and the code change together at the first clock edge after the causing input. An event arriving in the same cycle as its clear strobe leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enabled |
| line_err | input | 4 | Receive error pulses: overrun, parity, framing, break |
| rx_ready | input | 1 | Receive data ready / FIFO trigger level reached (level) |
| rx_timeout | input | 1 | Character timeout pulse from the receive FIFO |
| tx_empty | input | 1 | Transmit holding buffer empty (level) |
| hs_delta | input | 4 | Handshake change pulses: CTS, DSR, ring trailing edge, DCD |
| icr_wr | input | 1 | Enable register write strobe |
| icr_wdata | input | 8 | Enable register write data |
| isr_rd | input | 1 | Identification register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| thr_wr | input | 1 | Transmit buffer write strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| hsr_rd | input | 1 | Handshake status register read strobe |
| irq | output | 1 | Interrupt request, active high, registered |
| icr_rdata | output | 8 | Enable register read value |
| isr_rdata | output | 8 | Identification register read value |

## Verification
Directed sequences stack pairs of sources: line over data, data over timeout, and transmit-empty over handshake. These show that the priority order is resolved and not the arrival order. Reads of the identification register while a higher source is reported, next to reads while transmit-empty is reported, separate a qualified clear from a blind one. Events placed on the same cycle as their clear strobe show which of the two wins. A long stretch of random pulses, levels, strobes and enable writes is compared cycle by cycle with a reference model. It brings out interleavings the directed cases do not reach, such as FIFO mode toggling with a timeout pending.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int REG_W   = 8;
    localparam int NIB_W   = 4;
    localparam int ERR_W   = 4;
    localparam int DLT_W   = 4;
    localparam int SET_W   = (ERR_W > DLT_W) ? ERR_W : DLT_W;
    localparam int N_LATCH = 4;

    // latched source slots
    localparam int LAT_LINE  = 0;
    localparam int LAT_TMO   = 1;
    localparam int LAT_THRE  = 2;
    localparam int LAT_MODEM = 3;

    // enable register bit positions
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LINE,
        ST_RXDATA,
        ST_TMO,
        ST_THRE,
        ST_MODEM
    } irq_state_e;

    localparam logic [NIB_W-1:0] CODE_NONE   = 4'b0001;
    localparam logic [NIB_W-1:0] CODE_LINE   = 4'b0110;
    localparam logic [NIB_W-1:0] CODE_RXDATA = 4'b0100;
    localparam logic [NIB_W-1:0] CODE_TMO    = 4'b1100;
    localparam logic [NIB_W-1:0] CODE_THRE   = 4'b0010;
    localparam logic [NIB_W-1:0] CODE_MODEM  = 4'b0000;
    localparam logic [NIB_W-1:0] FIFO_TAG    = 4'b1100;
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch
    import uart_irq_pkg::*;
#(
    parameter int SW = SET_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] set_i,
    input  logic          clr_i,
    input  logic          off_i,
    output logic          pend_d_o,
    output logic          pend_q_o
);
    logic any_set;

    always_comb begin
        any_set  = |set_i;
        pend_d_o = !off_i && (any_set || (pend_q_o && !clr_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q_o <= 1'b0;
        else        pend_q_o <= pend_d_o;
    end

    // R12: a new event beats a clear arriving with it
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_i) && !off_i) |=> pend_q_o);

    // R12: a lone clear drops the source at the next edge
    a_r12_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(|set_i)) |=> !pend_q_o);
endmodule

// File: rtl/irq_prio_fsm.sv
module irq_prio_fsm
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_d_i,
    input  logic             rxdata_d_i,
    input  logic             tmo_d_i,
    input  logic             thre_d_i,
    input  logic             modem_d_i,
    input  logic [NIB_W-1:0] en_d_i,
    output irq_state_e       state_o,
    output logic             irq_o,
    output logic [NIB_W-1:0] code_o
);
    irq_state_e state_q, state_d;
    logic       irq_q, irq_d;
    logic       m_line, m_rx, m_tmo, m_thre, m_modem;

    always_comb begin
        m_line  = line_d_i   && en_d_i[EN_LINE];
        m_rx    = rxdata_d_i && en_d_i[EN_RX];
        m_tmo   = tmo_d_i    && en_d_i[EN_RX];
        m_thre  = thre_d_i   && en_d_i[EN_TX];
        m_modem = modem_d_i  && en_d_i[EN_MODEM];
        irq_d   = m_line || m_rx || m_tmo || m_thre || m_modem;
        if (m_line)       state_d = ST_LINE;
        else if (m_rx)    state_d = ST_RXDATA;
        else if (m_tmo)   state_d = ST_TMO;
        else if (m_thre)  state_d = ST_THRE;
        else if (m_modem) state_d = ST_MODEM;
        else              state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   code_o = CODE_NONE;
            ST_LINE:   code_o = CODE_LINE;
            ST_RXDATA: code_o = CODE_RXDATA;
            ST_TMO:    code_o = CODE_TMO;
            ST_THRE:   code_o = CODE_THRE;
            ST_MODEM:  code_o = CODE_MODEM;
            default:   code_o = CODE_NONE;
        endcase
    end

    assign state_o = state_q;
    assign irq_o   = irq_q;

    // R3: output line and reported code never disagree
    a_r3_irq_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (code_o != CODE_NONE));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [ERR_W-1:0] line_err,
    input  logic             rx_ready,
    input  logic             rx_timeout,
    input  logic             tx_empty,
    input  logic [DLT_W-1:0] hs_delta,
    input  logic             icr_wr,
    input  logic [REG_W-1:0] icr_wdata,
    input  logic             isr_rd,
    input  logic             rbr_rd,
    input  logic             thr_wr,
    input  logic             lsr_rd,
    input  logic             hsr_rd,
    output logic             irq,
    output logic [REG_W-1:0] icr_rdata,
    output logic [REG_W-1:0] isr_rdata
);
    logic [NIB_W-1:0]       icr_q, icr_d;
    logic                   tx_q, fifo_q;
    logic                   tx_rise, en_rise, thre_rd_clr;
    logic [SET_W-1:0]       set_m [N_LATCH];
    logic [N_LATCH-1:0]     clr_m, off_m, pend_d, pend_q;
    irq_state_e             state;
    logic [NIB_W-1:0]       code;
    logic                   unused_hi;

    assign unused_hi = ^icr_wdata[REG_W-1:NIB_W];

    always_comb begin
        icr_d       = icr_wr ? icr_wdata[NIB_W-1:0] : icr_q;
        tx_rise     = tx_empty && !tx_q;
        en_rise     = icr_wr && icr_wdata[EN_TX] && !icr_q[EN_TX] && tx_empty;
        thre_rd_clr = isr_rd && (state == ST_THRE);

        set_m[LAT_LINE]  = SET_W'(line_err);
        clr_m[LAT_LINE]  = lsr_rd;
        off_m[LAT_LINE]  = 1'b0;

        set_m[LAT_TMO]   = SET_W'(rx_timeout);
        clr_m[LAT_TMO]   = rbr_rd;
        off_m[LAT_TMO]   = !fifo_en;

        set_m[LAT_THRE]  = SET_W'({en_rise, tx_rise});
        clr_m[LAT_THRE]  = thr_wr || thre_rd_clr;
        off_m[LAT_THRE]  = 1'b0;

        set_m[LAT_MODEM] = SET_W'(hs_delta);
        clr_m[LAT_MODEM] = hsr_rd;
        off_m[LAT_MODEM] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            icr_q  <= '0;
            tx_q   <= 1'b0;
            fifo_q <= 1'b0;
        end else begin
            icr_q  <= icr_d;
            tx_q   <= tx_empty;
            fifo_q <= fifo_en;
        end
    end

    generate
        for (genvar g = 0; g < N_LATCH; g++) begin : g_src
            irq_evt_latch #(.SW(SET_W)) u_latch (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_i    (set_m[g]),
                .clr_i    (clr_m[g]),
                .off_i    (off_m[g]),
                .pend_d_o (pend_d[g]),
                .pend_q_o (pend_q[g])
            );
        end
    endgenerate

    irq_prio_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_d_i   (pend_d[LAT_LINE]),
        .rxdata_d_i (rx_ready),
        .tmo_d_i    (pend_d[LAT_TMO]),
        .thre_d_i   (pend_d[LAT_THRE]),
        .modem_d_i  (pend_d[LAT_MODEM]),
        .en_d_i     (icr_d),
        .state_o    (state),
        .irq_o      (irq),
        .code_o     (code)
    );

    assign icr_rdata = {{(REG_W-NIB_W){1'b0}}, icr_q};
    assign isr_rdata = {(fifo_q ? FIFO_TAG : {NIB_W{1'b0}}), code};

    // R2: all enables clear keeps the line quiet
    a_r2_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (icr_q == '0) |-> !irq);

    // R4: an enabled line source always owns the code
    a_r4_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[LAT_LINE] && icr_q[EN_LINE]) |-> (code == CODE_LINE));

    // R6: no timeout report without FIFO mode
    a_r6_tmo_needs_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_q |-> (code != CODE_TMO));

    // R7: reading the status while transmit-empty is reported drops it
    a_r7_thre_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && (code == CODE_THRE) && !tx_rise && !en_rise) |=> (code != CODE_THRE));

    // R8: a status read reporting another source keeps transmit-empty pending
    a_r8_thre_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && (code != CODE_THRE) && pend_q[LAT_THRE] && !thr_wr) |=> pend_q[LAT_THRE]);
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 0, rx_ready = 0, rx_timeout = 0, tx_empty = 0;
    logic [3:0] line_err = 0, hs_delta = 0;
    logic       icr_wr = 0, isr_rd = 0, rbr_rd = 0, thr_wr = 0, lsr_rd = 0, hsr_rd = 0;
    logic [7:0] icr_wdata = 0;
    logic       irq;
    logic [7:0] icr_rdata, isr_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    logic [3:0] m_icr = 0, m_code = 4'b0001;
    logic       m_line = 0, m_tmo = 0, m_thre = 0, m_msr = 0, m_txq = 0, m_fifo = 0, m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .line_err(line_err),
        .rx_ready(rx_ready), .rx_timeout(rx_timeout), .tx_empty(tx_empty),
        .hs_delta(hs_delta), .icr_wr(icr_wr), .icr_wdata(icr_wdata),
        .isr_rd(isr_rd), .rbr_rd(rbr_rd), .thr_wr(thr_wr), .lsr_rd(lsr_rd),
        .hsr_rd(hsr_rd), .irq(irq), .icr_rdata(icr_rdata), .isr_rdata(isr_rdata)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] prio(input logic [3:0] en, input logic ln,
                                        input logic rdy, input logic tm,
                                        input logic th, input logic ms);
        if (ln && en[2])      return 4'b0110;
        else if (rdy && en[0]) return 4'b0100;
        else if (tm && en[0])  return 4'b1100;
        else if (th && en[1])  return 4'b0010;
        else if (ms && en[3])  return 4'b0000;
        return 4'b0001;
    endfunction

    // one clock: advance model from the present inputs, then compare
    task automatic step(input string tag);
        logic [3:0] icr_n;
        logic ln, tm, th, ms;
        icr_n = icr_wr ? icr_wdata[3:0] : m_icr;
        ln = (|line_err) | (m_line & ~lsr_rd);
        tm = fifo_en & (rx_timeout | (m_tmo & ~rbr_rd));
        th = (tx_empty & ~m_txq) | (icr_wr & icr_wdata[1] & ~m_icr[1] & tx_empty)
           | (m_thre & ~thr_wr & ~(isr_rd & m_irq & (m_code == 4'b0010)));
        ms = (|hs_delta) | (m_msr & ~hsr_rd);
        @(posedge clk);
        m_code = prio(icr_n, ln, rx_ready, tm, th, ms);
        m_irq  = (m_code != 4'b0001);
        m_icr = icr_n; m_line = ln; m_tmo = tm; m_thre = th; m_msr = ms;
        m_txq = tx_empty; m_fifo = fifo_en;
        #1;
        line_err = 0; hs_delta = 0; rx_timeout = 0;
        icr_wr = 0; isr_rd = 0; rbr_rd = 0; thr_wr = 0; lsr_rd = 0; hsr_rd = 0;
        check({7'd0, irq}, {7'd0, m_irq}, tag);
        check(isr_rdata, {(m_fifo ? 4'b1100 : 4'b0000), m_code}, tag);
        check(icr_rdata, {4'b0000, m_icr}, tag);
    endtask

    task automatic wr_icr(input logic [7:0] v, input string tag);
        icr_wr = 1; icr_wdata = v;
        step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // reset state (R3)
        check({7'd0, irq}, 8'd0, "R3 reset irq");
        check(isr_rdata, 8'h01, "R3 reset code");
        check(icr_rdata, 8'h00, "R1 reset enables");

        // R1 upper bits read zero
        wr_icr(8'hFF, "R1 write");
        check(icr_rdata, 8'h0F, "R1 upper nibble zero");

        // R2 disabled: latched but quiet
        wr_icr(8'hF0, "R2 clear");
        line_err = 4'b0010; step("R2 pulse");
        check({7'd0, irq}, 8'd0, "R2 irq quiet");
        wr_icr(8'h04, "R2 enable line");
        check(isr_rdata, 8'h06, "R2 latched source reports");
        lsr_rd = 1; step("R4 clear");
        check(isr_rdata, 8'h01, "R3 idle code");

        // R4 over R5
        wr_icr(8'h0F, "R1 all on");
        line_err = 4'b0100; rx_ready = 1; step("R4 set");
        check(isr_rdata, 8'h06, "R4 line highest");
        lsr_rd = 1; step("R4 clear");
        check(isr_rdata, 8'h04, "R5 data ready");
        rx_ready = 0; step("R5 drop");
        check(isr_rdata, 8'h01, "R5 dropped");

        // R6 and R11
        fifo_en = 1; step("R11 fifo on");
        rx_timeout = 1; step("R6 set");
        check(isr_rdata, 8'hCC, "R6 timeout code R11 tag");
        rx_ready = 1; step("R5 over timeout");
        check(isr_rdata, 8'hC4, "R5 over timeout");
        rx_ready = 0; step("R6 back");
        check(isr_rdata, 8'hCC, "R6 timeout again");
        rbr_rd = 1; step("R6 clear");
        check(isr_rdata, 8'hC1, "R6 cleared by rbr");
        fifo_en = 0; rx_timeout = 1; step("R6 no fifo");
        check(isr_rdata, 8'h01, "R6 ignored without fifo R11");

        // R7
        tx_empty = 1; step("R7 rise");
        check(isr_rdata, 8'h02, "R7 thre code");
        isr_rd = 1; step("R7 read clear");
        check(isr_rdata, 8'h01, "R7 cleared by status read");
        tx_empty = 0; step("R7 low");
        tx_empty = 1; step("R7 rise2");
        thr_wr = 1; step("R7 write clear");
        check(isr_rdata, 8'h01, "R7 cleared by write");

        // R8
        tx_empty = 0; step("R8 low");
        tx_empty = 1; step("R8 rise");
        line_err = 4'b0001; step("R8 line");
        isr_rd = 1; step("R8 read during line");
        check(isr_rdata, 8'h06, "R8 line still");
        lsr_rd = 1; step("R8 line clear");
        check(isr_rdata, 8'h02, "R8 thre kept");

        // R9
        thr_wr = 1; wr_icr(8'h0D, "R9 disable tx");
        wr_icr(8'h0F, "R9 enable tx");
        check(isr_rdata, 8'h02, "R9 enable while empty");
        isr_rd = 1; step("R9 clear");

        // R10
        hs_delta = 4'b1000; step("R10 set");
        check(isr_rdata, 8'h00, "R10 modem code");
        check({7'd0, irq}, 8'd1, "R10 irq high");
        tx_empty = 0; step("R10 low");
        tx_empty = 1; step("R10 thre above modem");
        check(isr_rdata, 8'h02, "R10 lowest priority");
        thr_wr = 1; step("R10 thre gone");
        hsr_rd = 1; step("R10 clear");
        check(isr_rdata, 8'h01, "R10 cleared");

        // R12 set beats clear
        line_err = 4'b1000; lsr_rd = 1; step("R12 same cycle");
        check(isr_rdata, 8'h06, "R12 set wins");
        lsr_rd = 1; step("R12 clear");

        // random run
        for (int i = 0; i < N_RAND; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 8)  line_err = 4'($urandom);
            if ((r % 7) == 0) rx_timeout = 1;
            if ((r % 9) == 0) hs_delta = 4'($urandom);
            if ((r % 5) == 0) rx_ready = ~rx_ready;
            if ((r % 6) == 0) tx_empty = ~tx_empty;
            if (r == 50) fifo_en = ~fifo_en;
            if (r > 93) begin icr_wr = 1; icr_wdata = 8'($urandom); end
            isr_rd = ($urandom_range(0, 3) == 0);
            rbr_rd = ($urandom_range(0, 5) == 0);
            thr_wr = ($urandom_range(0, 7) == 0);
            lsr_rd = ($urandom_range(0, 5) == 0);
            hsr_rd = ($urandom_range(0, 5) == 0);
            step("R12 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule